// File: doc/BRIEF.md
# Interrupt Register Bank with Two-Deep Pending Bits

This block is one group of interrupt registers for a processor-visible peripheral. It watches a vector of raw event lines. A rising edge on a line whose mask bit is clear counts as one occurrence of that interrupt. Occurrences are recorded in a pending register that software clears by writing ones. The pending bits that are also enabled are ORed into one registered interrupt line toward the processor.

Each pending bit is backed by a small occurrence counter that can hold two occurrences. A single write-one-to-clear retires only one of them. A bit that caught two events therefore reads back as set after the first clear, and it needs a second clear to reach zero. The usual software idiom works unchanged: read the pending register and write the same value back, and only the bits that were seen are acknowledged.

Software reaches the four registers through a synchronous port with a word address, a write strobe and write data. Read data comes back one cycle after the address is presented. There is no read strobe: the read data register follows the address on every cycle.

Top module: `evt_intr_bank`

## Requirements
- R1: After reset the mask register reads all ones, the enable register reads zero, the pending register reads zero, and `irq_o` and `reg_rdata_o` are zero.
- R2: An occurrence is a rising edge on `evt_i[i]` (low in the previous cycle, high now) while mask bit i is 0. It sets pending bit i at that clock edge. An edge on a masked line is dropped and is not remembered: clearing the mask later does not set the bit.
- R3: Each pending bit counts at most two outstanding occurrences. Further occurrences while it holds two are discarded.
- R4: Writing to the pending register (word address 0) retires one occurrence for each data bit that is 1, and leaves bits written 0 unchanged. A bit that held two occurrences still reads 1 after one such write.
- R5: Two consecutive all-ones writes to the pending register, with no new occurrence in those two cycles, leave the pending register at zero.
- R6: When a clear and a new occurrence hit the same bit in the same cycle, one stored occurrence is retired first and the new one is then enqueued, so no event is lost.
- R7: The live status register (word address 1) returns `evt_i` as it is in the cycle the address is presented, with no latching or masking. Writes to it have no effect on any register.
- R8: `irq_o` is the OR over all bits of (pending AND enable), registered one cycle after that state. With the enable register at zero, `irq_o` stays low.
- R9: Word address 2 is the enable register and word address 3 is the mask register. Both are read/write and take the written data at the write edge. `reg_rdata_o` presents the register addressed in the previous cycle, with the value it held before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | W (32) | Raw event lines, one per interrupt bit |
| reg_addr_i | input | AW (2) | Register word address: 0 pending, 1 live, 2 enable, 3 mask |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | W (32) | Write data |
| reg_rdata_o | output | W (32) | Read data, one cycle after the address |
| irq_o | output | 1 | Interrupt request toward the processor |

## Verification
An edge driven on `evt_i` shows up in the pending bits at the next clock edge. A read of the pending register issued in the following cycle shows it one edge later. `irq_o` reflects pending and enable one edge after they change, and a register write is visible to a read presented in the next cycle. The bench drives all inputs just after a falling edge and keeps a cycle model. For each cycle, the model computes the expected read data and `irq_o` from its state before that cycle's edge, updates the state after the edge, and compares at the following falling edge. Every comparison therefore lands exactly on the edge at which the design's registered outputs are due.

// File: rtl/evt_intr_pkg.sv
package evt_intr_pkg;

  // Word addresses of the four registers in the group
  localparam int unsigned REG_PEND = 0;
  localparam int unsigned REG_LIVE = 1;
  localparam int unsigned REG_EN   = 2;
  localparam int unsigned REG_MASK = 3;

  // Per-bit occurrence count: 0, 1 or 2 stored events
  typedef logic [1:0] occ_cnt_t;
  localparam occ_cnt_t OCC_NONE = 2'd0;
  localparam occ_cnt_t OCC_MAX  = 2'd2;

  // A clear retires one stored occurrence, then a new one is enqueued,
  // saturating at OCC_MAX.
  function automatic occ_cnt_t occ_step(occ_cnt_t cur, logic clr, logic occ);
    occ_cnt_t nxt;
    nxt = (clr && (cur != OCC_NONE)) ? cur - 2'd1 : cur;
    if (occ && (nxt != OCC_MAX)) nxt = nxt + 2'd1;
    return nxt;
  endfunction

  // Rising-edge detection against the previous sample
  function automatic logic [31:0] rise_of(logic [31:0] now, logic [31:0] prev);
    return now & ~prev;
  endfunction

endpackage

// File: rtl/evt_rise_det.sv
module evt_rise_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= evt_i;
  end

  assign rise_o = evt_i & ~prev_q;
endmodule

// File: rtl/evt_occ_slot.sv
module evt_occ_slot
  import evt_intr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       occ_i,
  output logic [1:0] cnt_o,
  output logic       pend_o
);
  occ_cnt_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= OCC_NONE;
    else        cnt_q <= occ_step(cnt_q, clr_i, occ_i);
  end

  assign cnt_o  = cnt_q;
  assign pend_o = (cnt_q != OCC_NONE);
endmodule

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_intr_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  en_o,
  output logic [W-1:0]  mask_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] mask_q;
  logic         wr_en;
  logic         wr_mask;

  assign wr_en   = wr_i && (addr_i == AW'(REG_EN));
  assign wr_mask = wr_i && (addr_i == AW'(REG_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '1;
    end else begin
      if (wr_en)   en_q   <= wdata_i;
      if (wr_mask) mask_q <= wdata_i;
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/evt_intr_bank.sv
module evt_intr_bank
  import evt_intr_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  evt_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  reg_rdata_o,
  output logic          irq_o
);
  localparam int CW = 2 * W;

  // Named internal events, observed by the checker
  logic [W-1:0]  rise_v;   // raw rising edges
  logic [W-1:0]  occ_v;    // unmasked edges = occurrences
  logic [W-1:0]  clr_v;    // write-one-to-clear strobes
  logic [W-1:0]  pend_v;   // pending register view
  logic [CW-1:0] cnt_flat; // per-bit occurrence counts
  logic [W-1:0]  en_q;
  logic [W-1:0]  mask_q;
  logic          wr_pend;
  logic          wr_pend_all;
  logic          irq_q;
  logic [W-1:0]  rdata_q;

  evt_rise_det #(.W(W)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .rise_o (rise_v)
  );

  evt_cfg_regs #(.W(W), .AW(AW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .en_o    (en_q),
    .mask_o  (mask_q)
  );

  assign occ_v       = rise_v & ~mask_q;
  assign wr_pend     = reg_wr_i && (reg_addr_i == AW'(REG_PEND));
  assign clr_v       = wr_pend ? reg_wdata_i : '0;
  assign wr_pend_all = wr_pend && (&reg_wdata_i);

  for (genvar i = 0; i < W; i++) begin : g_slot
    evt_occ_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_v[i]),
      .occ_i  (occ_v[i]),
      .cnt_o  (cnt_flat[2*i +: 2]),
      .pend_o (pend_v[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(pend_v & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      case (reg_addr_i)
        AW'(REG_PEND): rdata_q <= pend_v;
        AW'(REG_LIVE): rdata_q <= evt_i;
        AW'(REG_EN):   rdata_q <= en_q;
        default:       rdata_q <= mask_q;
      endcase
    end
  end

  assign irq_o       = irq_q;
  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/evt_intr_bank_chk.sv
module evt_intr_bank_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_o,
  input logic [W-1:0]   pend_v,
  input logic [W-1:0]   en_q,
  input logic [W-1:0]   mask_q,
  input logic [W-1:0]   occ_v,
  input logic [W-1:0]   clr_v,
  input logic           wr_pend,
  input logic           wr_pend_all,
  input logic [2*W-1:0] cnt_flat
);
  // R2: with every line masked and nothing cleared, no pending bit appears
  p_mask_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mask_q) && (clr_v == '0)) |=> ((pend_v & ~$past(pend_v)) == '0));

  // R4: writing zeros to pending with no occurrence leaves it alone
  p_zero_write_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && (clr_v == '0) && (occ_v == '0)) |=> $stable(pend_v));

  // R5: two back-to-back all-ones clears with no occurrences empty the register
  p_double_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend_all && $past(wr_pend_all) && (occ_v == '0) && ($past(occ_v) == '0))
    |=> (pend_v == '0));

  // R8: enable zero keeps the request low
  p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_o);

  // R8: an enabled pending bit raises the request one edge later
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_v & en_q)) |=> irq_o);

  for (genvar i = 0; i < W; i++) begin : g_bit
    // R3: a count never exceeds two
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[2*i +: 2] != 2'd3));

    // R4: a bit holding two stays set after one clear
    p_requeue_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_flat[2*i +: 2] == 2'd2) && clr_v[i]) |=> pend_v[i]);

    // R6: clear plus occurrence on a set bit keeps it set
    p_clear_and_occ_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[i] && occ_v[i]) |=> pend_v[i]);
  end
endmodule

bind evt_intr_bank evt_intr_bank_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_o       (irq_o),
  .pend_v      (pend_v),
  .en_q        (en_q),
  .mask_q      (mask_q),
  .occ_v       (occ_v),
  .clr_v       (clr_v),
  .wr_pend     (wr_pend),
  .wr_pend_all (wr_pend_all),
  .cnt_flat    (cnt_flat)
);

// File: tb/evt_intr_bank_test.sv
`timescale 1ns/1ps
module evt_intr_bank_test;
  localparam int W  = 32;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  evt = '0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [W-1:0]  wdata = '0;
  wire  [W-1:0]  rdata;
  wire           irq;

  always #2 clk = ~clk;

  evt_intr_bank #(.W(W), .AW(AW)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  // Bench model of the register group
  int           m_cnt [W];
  logic [W-1:0] m_prev, m_en, m_mask;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 0;

  function automatic int cnt_next(int c, bit clr, bit occ);
    int r;
    r = c;
    if (clr && r > 0) r = r - 1;
    if (occ && r < 2) r = r + 1;
    return r;
  endfunction

  function automatic logic [W-1:0] m_pend();
    logic [W-1:0] p;
    for (int i = 0; i < W; i++) p[i] = (m_cnt[i] != 0);
    return p;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive after a falling edge, model the rising edge, compare after the next falling edge
  task automatic step(string tag, logic [W-1:0] e, logic w, logic [AW-1:0] a, logic [W-1:0] d);
    logic [W-1:0] exp_rd;
    logic         exp_irq;
    logic [W-1:0] occ;
    logic [W-1:0] clr;
    evt = e; wr = w; addr = a; wdata = d;
    case (a)
      2'd0:    exp_rd = m_pend();
      2'd1:    exp_rd = e;
      2'd2:    exp_rd = m_en;
      default: exp_rd = m_mask;
    endcase
    exp_irq = |(m_pend() & m_en);
    occ = e & ~m_prev & ~m_mask;
    clr = (w && a == 2'd0) ? d : '0;
    @(posedge clk);
    for (int i = 0; i < W; i++) m_cnt[i] = cnt_next(m_cnt[i], clr[i], occ[i]);
    if (w && a == 2'd2) m_en = d;
    if (w && a == 2'd3) m_mask = d;
    m_prev = e;
    @(negedge clk);
    check({tag, " rdata"}, rdata, exp_rd);
    check({tag, " irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, exp_irq});
  endtask

  task automatic rd(string tag, logic [AW-1:0] a);
    step(tag, evt, 1'b0, a, '0);
  endtask
  task automatic wrr(string tag, logic [AW-1:0] a, logic [W-1:0] d);
    step(tag, evt, 1'b1, a, d);
  endtask
  task automatic ev(string tag, logic [W-1:0] e);
    step(tag, e, 1'b0, 2'd0, '0);
  endtask

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < W; i++) m_cnt[i] = 0;
    m_prev = '0; m_en = '0; m_mask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    check("R1 rdata after reset", rdata, '0);
    check("R1 irq after reset", {{(W-1){1'b0}}, irq}, '0);
    rd("R1 mask", 2'd3);
    rd("R1 enable", 2'd2);
    rd("R1 pending", 2'd0);

    // R9: configuration registers
    wrr("R9 unmask", 2'd3, '0);
    rd("R9 mask readback", 2'd3);
    wrr("R9 enable write", 2'd2, 32'h0000_0000);

    // R2: unmasked edge sets pending
    ev("R2 edge", 32'h1);
    rd("R2 pending bit0", 2'd0);

    // R7: live status, writes ignored
    wrr("R7 write live", 2'd1, '1);
    rd("R7 live", 2'd1);
    rd("R7 pending unchanged", 2'd0);

    // R3: three edges on bit1 saturate at two
    ev("R3", 32'h3); ev("R3", 32'h1); ev("R3", 32'h3);
    ev("R3", 32'h1); ev("R3", 32'h3);
    wrr("R3 first clear", 2'd0, 32'h2);
    rd("R3 requeued", 2'd0);
    // R4: zero write unchanged, second clear empties
    wrr("R4 zero write", 2'd0, '0);
    rd("R4 unchanged", 2'd0);
    wrr("R4 second clear", 2'd0, 32'h2);
    rd("R4 bit1 clear", 2'd0);

    // R5: double occurrences on all bits, two all-ones clears
    ev("R5", '0); ev("R5", '1); ev("R5", '0); ev("R5", '1);
    wrr("R5 clear one", 2'd0, '1);
    rd("R5 still set", 2'd0);
    ev("R5", '1);
    wrr("R5 clear a", 2'd0, '1);
    wrr("R5 clear b", 2'd0, '1);
    rd("R5 empty", 2'd0);

    // R6: clear and occurrence together
    ev("R6", '0); ev("R6", 32'h1); ev("R6", '0);
    step("R6 clear+edge", 32'h1, 1'b1, 2'd0, 32'h1);
    rd("R6 kept", 2'd0);

    // R8: enable gating and latency
    wrr("R8 enable bit0", 2'd2, 32'h1);
    rd("R8 irq high", 2'd0);
    wrr("R8 disable", 2'd2, '0);
    rd("R8 irq low", 2'd0);
    rd("R8 irq low", 2'd0);

    // R2: masked edge is dropped, not remembered
    wrr("R2 clear", 2'd0, '1);
    wrr("R2 clear", 2'd0, '1);
    wrr("R2 mask bit5", 2'd3, 32'h20);
    ev("R2", '0); ev("R2", 32'h20);
    wrr("R2 unmask", 2'd3, '0);
    rd("R2 masked dropped", 2'd0);

    // Random traffic across all requirements
    for (int k = 0; k < 4000; k++) begin
      logic [W-1:0] e;
      logic [W-1:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      e = (sel < 3) ? evt : $urandom();
      d = (sel == 0) ? '1 : (sel == 1) ? '0 : $urandom();
      step("R4 R6 random", e, ($urandom_range(0, 2) == 0), AW'($urandom_range(0, 3)), d);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule